// File: doc/BRIEF.md
# Burst-Quantum DMA Channel Arbiter

This block chooses which of several DMA channels owns the transfer datapath. Each channel presents a request line, an enable, a priority class bit, a 4-bit exponent R and its count N of transfers still to do. At an arbitration point the arbiter picks one eligible channel and grants it a burst of min(N, 2^R) transfers. It keeps that grant until the datapath has reported that many completed transfers, and then it arbitrates again.

Because the datapath writes back the reduced N after each burst, a long job is broken into full 2^R bursts followed by one short burst for the remainder. Between these bursts a channel with higher priority can win the next grant. A low-value R keeps latency short for other channels. A high-value R lets one channel hold the datapath for up to 2^R transfers. The descriptor fetch, the bus transfers and the write-back are not part of this block.

Top module: `bq_arb`

## Requirements
- R1: While reset is high and in the first cycle after it, `grant` is all zero, `arb_pulse` is 0 and `burst_len` is 0.
- R2: Channel i is eligible only when `req[i]`, `en[i]` and a nonzero N for channel i are all present. When no channel is eligible at an arbitration point, `grant` stays all zero.
- R3: Among eligible channels, those with `hipri[i]`=1 win over those with 0. Within the winning class the lowest index wins. Bit i of `grant` stands for channel i.
- R4: On the clock edge that grants a channel, `burst_len` becomes min(N, 2^R) of that channel, where N is taken from `n_left[i*16 +: 16]` and R from `rpow[i*4 +: 4]`. For example, R=4 and N=40 give 16.
- R5: Suppose N is larger than 2^R and is not a multiple of it, and N is reduced by each finished burst. The successive grants then have a length of 2^R until fewer than 2^R transfers remain, and the last grant has the length of the remaining N.
- R6: A granted channel keeps `grant` unchanged until `burst_len` pulses of `xfer_done` have been counted. Requests, enables or priorities that change in the meantime do not affect it.
- R7: On the edge that counts the last `xfer_done` of a burst, `grant` and `burst_len` drop to zero and `arb_pulse` rises for exactly one cycle. The next grant is decided on the following edge.
- R8: `xfer_done` pulses that arrive while no channel is granted are ignored. They do not shorten the next burst.
- R9: `grant` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 6 | Per-channel request lines |
| en | input | 6 | Per-channel enable |
| hipri | input | 6 | Per-channel high-priority class bit |
| rpow | input | 24 | Per-channel 4-bit burst exponent R, channel i in bits [4i+3:4i] |
| n_left | input | 96 | Per-channel remaining transfer count N, channel i in bits [16i+15:16i] |
| xfer_done | input | 1 | One pulse per completed transfer from the datapath |
| grant | output | 6 | One-hot grant, all zero when no channel is granted |
| burst_len | output | 16 | Transfers in the current burst, zero when no channel is granted |
| arb_pulse | output | 1 | One-cycle pulse marking the end of a burst |

## Verification
The selection logic is tried with several request patterns:
- mixed priority classes, which shows that class outranks index;
- two channels in the same class, which shows the lowest-index tie-break;
- requests with the enable low or with N at zero, which shows the eligibility gating.

The burst logic is tried in three ways:
- A long job with a remainder (N=20, R=3), whose N is written back after each burst, must produce the length sequence 8, 8, 4.
- A high-priority request raised in the middle of a low-priority burst must not take the grant until the pulse that closes the burst.
- Transfer strobes sent while the arbiter is idle must leave the next burst at its full length.

// File: rtl/bq_arb_pkg.sv
package bq_arb_pkg;

    localparam int unsigned DEF_NUM_CH = 6;
    localparam int unsigned DEF_R_W    = 4;
    localparam int unsigned DEF_CNT_W  = 16;

    typedef enum logic {
        ARB_IDLE  = 1'b0,
        ARB_BURST = 1'b1
    } arb_state_e;

    // Isolate the lowest set bit of a request vector.
    function automatic logic [DEF_NUM_CH-1:0] lowest_bit(input logic [DEF_NUM_CH-1:0] v);
        return v & (~v + DEF_NUM_CH'(1));
    endfunction

endpackage

// File: rtl/bq_arb_pick.sv
module bq_arb_pick
    import bq_arb_pkg::*;
#(
    parameter int unsigned NUM_CH = DEF_NUM_CH,
    parameter int unsigned R_W    = DEF_R_W,
    parameter int unsigned CNT_W  = DEF_CNT_W
) (
    input  logic [NUM_CH-1:0]       req,
    input  logic [NUM_CH-1:0]       en,
    input  logic [NUM_CH-1:0]       hipri,
    input  logic [NUM_CH*R_W-1:0]   rpow,
    input  logic [NUM_CH*CNT_W-1:0] n_left,
    output logic                    any_elig,
    output logic [NUM_CH-1:0]       win_oh,
    output logic [CNT_W-1:0]        win_len
);

    localparam int unsigned Q_W = CNT_W + 1;

    logic [NUM_CH-1:0] elig;
    logic [NUM_CH-1:0] hi_elig;
    logic [NUM_CH-1:0] cand;
    logic [R_W-1:0]    win_r;
    logic [CNT_W-1:0]  win_n;
    logic [Q_W-1:0]    quantum;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CH; gi++) begin : g_elig
            assign elig[gi] = req[gi] & en[gi] & (|n_left[gi*CNT_W +: CNT_W]);
        end
    endgenerate

    assign hi_elig  = elig & hipri;
    assign cand     = (|hi_elig) ? hi_elig : elig;
    assign win_oh   = cand & (~cand + NUM_CH'(1));
    assign any_elig = |elig;

    always_comb begin
        win_r = '0;
        win_n = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            win_r = win_r | (rpow[i*R_W +: R_W] & {R_W{win_oh[i]}});
            win_n = win_n | (n_left[i*CNT_W +: CNT_W] & {CNT_W{win_oh[i]}});
        end
    end

    // 2^R as a wider value; a zero result means the shift left the range.
    assign quantum = Q_W'(1) << win_r;

    always_comb begin
        if (quantum == '0 || {1'b0, win_n} <= quantum) begin
            win_len = win_n;
        end else begin
            win_len = quantum[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/bq_burst_cnt.sv
module bq_burst_cnt #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic [CNT_W-1:0] len,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || load) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign last = step && (cnt_q == len - CNT_W'(1));

endmodule

// File: rtl/bq_arb.sv
module bq_arb
    import bq_arb_pkg::*;
#(
    parameter int unsigned NUM_CH = DEF_NUM_CH,
    parameter int unsigned R_W    = DEF_R_W,
    parameter int unsigned CNT_W  = DEF_CNT_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_CH-1:0]       req,
    input  logic [NUM_CH-1:0]       en,
    input  logic [NUM_CH-1:0]       hipri,
    input  logic [NUM_CH*R_W-1:0]   rpow,
    input  logic [NUM_CH*CNT_W-1:0] n_left,
    input  logic                    xfer_done,
    output logic [NUM_CH-1:0]       grant,
    output logic [CNT_W-1:0]        burst_len,
    output logic                    arb_pulse
);

    arb_state_e        state_q;
    logic [NUM_CH-1:0] grant_q;
    logic [CNT_W-1:0]  len_q;
    logic              pulse_q;

    logic              any_elig;
    logic [NUM_CH-1:0] win_oh;
    logic [CNT_W-1:0]  win_len;
    logic              load;
    logic              step;
    logic              last;

    bq_arb_pick #(
        .NUM_CH (NUM_CH),
        .R_W    (R_W),
        .CNT_W  (CNT_W)
    ) u_pick (
        .req      (req),
        .en       (en),
        .hipri    (hipri),
        .rpow     (rpow),
        .n_left   (n_left),
        .any_elig (any_elig),
        .win_oh   (win_oh),
        .win_len  (win_len)
    );

    assign load = (state_q == ARB_IDLE) && any_elig;
    assign step = (state_q == ARB_BURST) && xfer_done;

    bq_burst_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .step (step),
        .len  (len_q),
        .last (last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ARB_IDLE;
            grant_q <= '0;
            len_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            case (state_q)
                ARB_IDLE: begin
                    if (any_elig) begin
                        state_q <= ARB_BURST;
                        grant_q <= win_oh;
                        len_q   <= win_len;
                    end
                end
                ARB_BURST: begin
                    if (last) begin
                        state_q <= ARB_IDLE;
                        grant_q <= '0;
                        len_q   <= '0;
                        pulse_q <= 1'b1;
                    end
                end
                default: state_q <= ARB_IDLE;
            endcase
        end
    end

    assign grant     = grant_q;
    assign burst_len = len_q;
    assign arb_pulse = pulse_q;

endmodule

// File: rtl/bq_arb_chk.sv
module bq_arb_chk #(
    parameter int unsigned NUM_CH = 6,
    parameter int unsigned CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] req,
    input logic [NUM_CH-1:0] en,
    input logic [NUM_CH-1:0] grant,
    input logic [CNT_W-1:0]  burst_len,
    input logic              xfer_done,
    input logic              arb_pulse
);

    logic [CNT_W-1:0] seen_q;

    always_ff @(posedge clk) begin
        if (rst || grant == '0) begin
            seen_q <= '0;
        end else if (xfer_done) begin
            seen_q <= seen_q + CNT_W'(1);
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)); // R9

    AST_NEW_GRANT_ELIG: assert property (@(posedge clk) disable iff (rst)
        (grant != '0 && $past(grant) == '0) |-> (($past(req) & $past(en) & grant) == grant)); // R2

    AST_GRANT_HELD: assert property (@(posedge clk) disable iff (rst)
        (grant != '0 && !xfer_done) |=> (grant == $past(grant))); // R6

    AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (rst)
        (grant != '0) |-> (burst_len != '0 && seen_q < burst_len)); // R4

    AST_BURST_CLOSE: assert property (@(posedge clk) disable iff (rst)
        (grant != '0 && xfer_done && seen_q == burst_len - CNT_W'(1)) |=> (arb_pulse && grant == '0)); // R7

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        arb_pulse |=> !arb_pulse); // R7

    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        arb_pulse |-> ($past(grant) != '0 && $past(xfer_done))); // R8

endmodule

bind bq_arb bq_arb_chk #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W)
) u_bq_arb_chk (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .en        (en),
    .grant     (grant),
    .burst_len (burst_len),
    .xfer_done (xfer_done),
    .arb_pulse (arb_pulse)
);

// File: tb/test_bq_arb.sv
module test_bq_arb;

    localparam int NCH = 6;
    localparam int RW  = 4;
    localparam int CW  = 16;
    localparam int WATCHDOG = 200000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NCH-1:0]    req = '0;
    logic [NCH-1:0]    en = '0;
    logic [NCH-1:0]    hipri = '0;
    logic [NCH*RW-1:0] rpow = '0;
    logic [NCH*CW-1:0] n_left = '0;
    logic              xfer_done = 1'b0;
    logic [NCH-1:0]    grant;
    logic [CW-1:0]     burst_len;
    logic              arb_pulse;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done_flag = 1'b0;

    always #4 clk = ~clk;

    bq_arb i_bq_arb (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .en        (en),
        .hipri     (hipri),
        .rpow      (rpow),
        .n_left    (n_left),
        .xfer_done (xfer_done),
        .grant     (grant),
        .burst_len (burst_len),
        .arb_pulse (arb_pulse)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done_flag) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<%0d", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_ch(input int i, input bit rq, input bit e, input bit hp, input int r, input int n);
        req[i]            = rq;
        en[i]             = e;
        hipri[i]          = hp;
        rpow[i*RW +: RW]  = RW'(r);
        n_left[i*CW +: CW] = CW'(n);
    endtask

    task automatic clr_all();
        req = '0; en = '0; hipri = '0; rpow = '0; n_left = '0;
    endtask

    // Send cnt strobes; grant must hold until the last one is counted.
    task automatic dones(input int cnt, input int exp_grant, input string tag);
        for (int k = 0; k < cnt; k++) begin
            xfer_done = 1'b1;
            step();
            if (k < cnt - 1) chk(tag, int'(grant), exp_grant);
        end
        xfer_done = 1'b0;
    endtask

    task automatic close_burst(input string tag);
        chk({tag, " pulse"}, int'(arb_pulse), 1);
        chk({tag, " grant cleared"}, int'(grant), 0);
        step();
        chk({tag, " pulse single"}, int'(arb_pulse), 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) step();
        chk("R1 grant in reset", int'(grant), 0);
        rst = 1'b0;
        step();
        chk("R1 grant", int'(grant), 0);
        chk("R1 pulse", int'(arb_pulse), 0);
        chk("R1 len", int'(burst_len), 0);
    endtask

    task automatic t_eligibility();
        clr_all();
        set_ch(1, 1'b1, 1'b0, 1'b1, 2, 5);   // not enabled
        set_ch(2, 1'b1, 1'b1, 1'b0, 2, 0);   // nothing left
        set_ch(3, 1'b0, 1'b1, 1'b1, 2, 5);   // no request
        step(); step();
        chk("R2 no eligible channel", int'(grant), 0);
        set_ch(4, 1'b1, 1'b1, 1'b0, 2, 3);
        step();
        chk("R2 only eligible wins", int'(grant), 32'h10);
        chk("R4 short job length", int'(burst_len), 3);
        clr_all();
        dones(3, 32'h10, "R6 hold basic");
        close_burst("R7 basic");
        chk("R2 idle after requests gone", int'(grant), 0);
    endtask

    task automatic t_priority();
        clr_all();
        set_ch(1, 1'b1, 1'b1, 1'b0, 0, 1);
        set_ch(2, 1'b1, 1'b1, 1'b0, 0, 1);
        set_ch(4, 1'b1, 1'b1, 1'b1, 0, 1);
        step();
        chk("R3 high class first", int'(grant), 32'h10);
        chk("R4 R=0 length", int'(burst_len), 1);
        set_ch(4, 1'b0, 1'b1, 1'b1, 0, 1);
        dones(1, 32'h10, "R6 prio");
        close_burst("R7 prio");
        chk("R3 lowest index in low class", int'(grant), 32'h02);
        dones(1, 32'h02, "R6 prio2");
        clr_all();
        close_burst("R7 prio2");
        set_ch(3, 1'b1, 1'b1, 1'b1, 1, 7);
        set_ch(5, 1'b1, 1'b1, 1'b1, 1, 7);
        step();
        chk("R3 lowest index in high class", int'(grant), 32'h08);
        chk("R4 R=1 length", int'(burst_len), 2);
        clr_all();
        dones(2, 32'h08, "R6 prio3");
        close_burst("R7 prio3");
    endtask

    task automatic t_nonpreempt();
        clr_all();
        set_ch(5, 1'b1, 1'b1, 1'b0, 3, 8);
        step();
        chk("R6 low channel granted", int'(grant), 32'h20);
        chk("R4 R=3 length", int'(burst_len), 8);
        set_ch(0, 1'b1, 1'b1, 1'b1, 2, 5);
        dones(8, 32'h20, "R6 not preempted by high request");
        set_ch(5, 1'b0, 1'b1, 1'b0, 3, 0);
        chk("R7 pulse after burst", int'(arb_pulse), 1);
        chk("R7 grant zero at pulse", int'(grant), 0);
        step();
        chk("R7 re-arbitrated winner", int'(grant), 32'h01);
        chk("R4 winner length", int'(burst_len), 4);
        clr_all();
        dones(4, 32'h01, "R6 hold high");
        close_burst("R7 high");
    endtask

    task automatic t_remainder();
        int n;
        int exp_len[3] = '{8, 8, 4};
        clr_all();
        n = 20;
        set_ch(0, 1'b1, 1'b1, 1'b0, 3, n);
        for (int b = 0; b < 3; b++) begin
            step();
            chk("R5 burst grant", int'(grant), 32'h01);
            chk("R5 burst length", int'(burst_len), exp_len[b]);
            dones(exp_len[b], 32'h01, "R6 remainder hold");
            chk("R7 remainder pulse", int'(arb_pulse), 1);
            n = n - exp_len[b];
            set_ch(0, 1'b1, 1'b1, 1'b0, 3, n);
        end
        step();
        chk("R2 done job not granted", int'(grant), 0);
        clr_all();
        set_ch(2, 1'b1, 1'b1, 1'b0, 4, 40);
        step();
        chk("R4 R=4 gives 16", int'(burst_len), 16);
        clr_all();
        dones(16, 32'h04, "R6 R=4 hold");
        close_burst("R7 R=4");
    endtask

    task automatic t_idle_strobes();
        clr_all();
        xfer_done = 1'b1;
        repeat (3) step();
        chk("R8 no grant from strobes", int'(grant), 0);
        chk("R8 no pulse from strobes", int'(arb_pulse), 0);
        set_ch(3, 1'b1, 1'b1, 1'b0, 1, 9);
        xfer_done = 1'b0;
        step();
        chk("R8 grant after idle strobes", int'(grant), 32'h08);
        xfer_done = 1'b1;
        step();
        xfer_done = 1'b0;
        chk("R8 burst not shortened", int'(grant), 32'h08);
        chk("R8 no early pulse", int'(arb_pulse), 0);
        clr_all();
        dones(1, 32'h08, "R6 idle");
        close_burst("R7 idle");
    endtask

    initial begin
        t_reset();
        t_eligibility();
        t_priority();
        t_nonpreempt();
        t_remainder();
        t_idle_strobes();
        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule